// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one access (load, store or instruction fetch) made in one of four privilege modes (0 is kernel). Most requests are answered by walking a three-level table in memory. The walker issues one 8-byte read per level over a simple request/response port. It then returns the physical address together with read, write and execute grants. If the walk cannot complete, it returns a fault code instead.

Two kinds of request never reach memory. The first is a physical-bypass request, which passes the address through unchanged. The second is a kernel access to the direct-mapped superpage window, which is translated by rewiring address bits. A non-canonical address is also refused before any table read.

The walker takes one request at a time. It raises `req_ready` only while idle, and it ends every request with a one-cycle pulse on exactly one of `done` or `fault`. The table root comes from the `ptbr` input and is sampled when a request is accepted.

Top module: `ptw_walker`

## Requirements
- R1: With `req_phys` high, the walker answers with `done`, `out_paddr` equal to `req_vaddr` and `out_prot` = 3'b111 (bit 0 read, bit 1 write, bit 2 execute). The outcome pulse comes on the second rising edge after acceptance, and no memory read is made.
- R2: If bits 63:42 of the address are not all equal, the walker ends with `fault` and code 1 (access violation) without reading memory.
- R3: A canonical address with bit 63 set and bits 42:41 = 2'b10, requested in mode 0, completes without a memory read. The result is `out_prot` = 3'b111 and an `out_paddr` whose bits 39:0 are the address bits 39:0, whose bit 43 is address bit 40, and whose other bits are zero.
- R4: The same superpage address requested in any mode other than 0 ends with fault code 1.
- R5: Every other address is walked in three reads. The first read is at `ptbr` + 8 × addr[42:33]. The second and third are at base + 8 × addr[32:23] and base + 8 × addr[22:13], where each base is bits 63:32 of the previous entry shifted left by 13.
- R6: A table entry at any level whose bit 0 (valid) is clear ends the walk with fault code 0 (not valid), and no further read is made.
- R7: A first- or second-level entry with bit 8 (kernel read enable) clear ends the walk with fault code 1.
- R8: In the leaf, entry bit 8+mode grants read and execute, and entry bit 12+mode grants write. A successful walk returns `out_paddr` = (entry bits 63:32 shifted left by 13) OR addr[12:0].
- R9: If the leaf grants nothing for the requested access, the fault code is 1. Access codes are 0 load (needs read), 1 store (needs write) and 2 fetch (needs execute); code 3 is handled as a load.
- R10: Leaf entry bits 1, 2 and 3 remove the read, write and execute grants, in that order. If this removes the requested access, the fault code is 2 for read, 4 for write and 3 for execute. Otherwise the trimmed grants are returned in `out_prot`.
- R11: Each accepted request produces exactly one one-cycle pulse on `done` or `fault`, never both. `req_ready` is high only when idle, and a `req_valid` raised while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 64 | Virtual address |
| req_access | input | 2 | 0 load, 1 store, 2 fetch |
| req_mode | input | 2 | Privilege mode, 0 is kernel |
| req_phys | input | 1 | Physical-bypass request |
| ptbr | input | 64 | Root table base address |
| mem_req_valid | output | 1 | One-cycle table read request |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry |
| done | output | 1 | Translation succeeded (pulse) |
| fault | output | 1 | Translation failed (pulse) |
| fault_code | output | 3 | 0 not valid, 1 access violation, 2 read, 3 execute, 4 write |
| out_paddr | output | 64 | Physical address |
| out_prot | output | 3 | Granted read/write/execute |

## Verification
The bench builds the walker with its default parameters. These are a 43-bit virtual space, 8 KiB pages, 10-bit indexes, three levels and two mode bits. With these values, the canonical-top-bit test, the superpage window at bits 42:41 and the bit 40 to bit 43 copy can all be hit with literal addresses. All four per-mode enable positions of the leaf can be reached the same way. Each level index is set to a distinct non-zero value, so a mix-up between levels would show in the read addresses.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

  localparam int PTE_FLAG_W  = 16;
  localparam int PTE_V_BIT   = 0;
  localparam int PTE_FO_LSB  = 1;
  localparam int PTE_RE_BASE = 8;
  localparam int PTE_WE_BASE = 12;

  typedef enum logic [2:0] {
    FLT_TNV = 3'd0,
    FLT_ACV = 3'd1,
    FLT_FOR = 3'd2,
    FLT_FOE = 3'd3,
    FLT_FOW = 3'd4
  } ptw_fault_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } ptw_access_e;

  typedef enum logic [1:0] {
    RGN_WALK   = 2'd0,
    RGN_BYPASS = 2'd1,
    RGN_SUPER  = 2'd2,
    RGN_DENY   = 2'd3
  } ptw_region_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_ISSUE  = 2'd2,
    ST_WAIT   = 2'd3
  } ptw_state_e;

endpackage

// File: rtl/ptw_region_decode.sv
`timescale 1ns/1ps
module ptw_region_decode
  import ptw_pkg::*;
#(
  parameter int VA_W        = 64,
  parameter int PA_W        = 64,
  parameter int VIRT_BITS   = 43,
  parameter int MODE_W      = 2,
  parameter int SP_LOW_BITS = 40,
  parameter int SP_HI_POS   = 43
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [MODE_W-1:0] mode,
  input  logic              phys_mode,
  output ptw_region_e       region,
  output logic [PA_W-1:0]   sp_paddr
);

  localparam int HI_W = VA_W - VIRT_BITS + 1;

  logic [HI_W-1:0] hi_bits;
  logic            canonical;
  logic            in_window;

  assign hi_bits   = vaddr[VA_W-1:VIRT_BITS-1];
  assign canonical = (hi_bits == '0) || (hi_bits == '1);
  assign in_window = vaddr[VA_W-1] && (vaddr[VIRT_BITS-1:VIRT_BITS-2] == 2'b10);

  assign sp_paddr = PA_W'(vaddr[SP_LOW_BITS-1:0])
                  | (PA_W'(vaddr[SP_LOW_BITS]) << SP_HI_POS);

  always_comb begin
    if (phys_mode) begin
      region = RGN_BYPASS;
    end else if (!canonical) begin
      region = RGN_DENY;
    end else if (in_window) begin
      region = (mode == '0) ? RGN_SUPER : RGN_DENY;
    end else begin
      region = RGN_WALK;
    end
  end

endmodule

// File: rtl/ptw_index_gen.sv
`timescale 1ns/1ps
module ptw_index_gen #(
  parameter int ADDR_W   = 64,
  parameter int IDX_BITS = 10,
  parameter int LEVELS   = 3,
  parameter int LVL_W    = 2
) (
  input  logic [IDX_BITS*LEVELS-1:0] vpn,
  input  logic [ADDR_W-1:0]          base,
  input  logic [LVL_W-1:0]           level,
  output logic [ADDR_W-1:0]          entry_addr
);

  localparam int ENTRY_SHIFT = 3;

  logic [IDX_BITS-1:0] idx [LEVELS];
  logic [IDX_BITS-1:0] idx_sel;

  // level 0 takes the most significant slice of the page number
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign idx[g] = vpn[IDX_BITS*(LEVELS-1-g) +: IDX_BITS];
  end

  always_comb begin
    idx_sel = idx[0];
    for (int l = 0; l < LEVELS; l++) begin
      if (level == LVL_W'(l)) idx_sel = idx[l];
    end
  end

  assign entry_addr = base + (ADDR_W'(idx_sel) << ENTRY_SHIFT);

endmodule

// File: rtl/ptw_leaf_check.sv
`timescale 1ns/1ps
module ptw_leaf_check
  import ptw_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic [PTE_FLAG_W-1:0] flags,
  input  logic [1:0]            access,
  input  logic [MODE_W-1:0]     mode,
  output logic                  grant_ok,
  output ptw_fault_e            code,
  output logic [2:0]            prot
);

  localparam int MODES = 1 << MODE_W;

  logic [MODES-1:0] re_field;
  logic [MODES-1:0] we_field;
  logic [2:0]       raw;
  logic [2:0]       need;
  logic [2:0]       fo_bits;
  logic [2:0]       trimmed;
  logic             unused_flag_bits;

  assign re_field = flags[PTE_RE_BASE +: MODES];
  assign we_field = flags[PTE_WE_BASE +: MODES];
  assign fo_bits  = flags[PTE_FO_LSB +: 3];
  assign unused_flag_bits = ^{flags[PTE_V_BIT], flags[PTE_RE_BASE-1:PTE_FO_LSB+3]};

  // prot layout {exec, write, read}
  assign raw     = {re_field[mode], we_field[mode], re_field[mode]};
  assign trimmed = raw & ~fo_bits;

  always_comb begin
    unique case (access)
      ACC_STORE: need = 3'b010;
      ACC_FETCH: need = 3'b100;
      default:   need = 3'b001;
    endcase
  end

  always_comb begin
    grant_ok = 1'b0;
    code     = FLT_ACV;
    if ((raw & need) == 3'b000) begin
      code = FLT_ACV;
    end else if ((trimmed & need) == 3'b000) begin
      if (need[2])      code = FLT_FOE;
      else if (need[1]) code = FLT_FOW;
      else              code = FLT_FOR;
    end else begin
      grant_ok = 1'b1;
    end
  end

  assign prot = trimmed;

endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W        = 64,
  parameter int PA_W        = 64,
  parameter int PTE_W       = 64,
  parameter int VIRT_BITS   = 43,
  parameter int PAGE_BITS   = 13,
  parameter int IDX_BITS    = 10,
  parameter int LEVELS      = 3,
  parameter int MODE_W      = 2,
  parameter int SP_LOW_BITS = 40,
  parameter int SP_HI_POS   = 43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_access,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_phys,
  input  logic [VA_W-1:0]   ptbr,
  output logic              mem_req_valid,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [2:0]        fault_code,
  output logic [PA_W-1:0]   out_paddr,
  output logic [2:0]        out_prot
);

  localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int VPN_W     = IDX_BITS * LEVELS;
  localparam int FRAME_LSB = PTE_W / 2;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  ptw_state_e        state_q, state_d;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q;
  logic [MODE_W-1:0] mode_q;
  logic              phys_q;
  logic [VA_W-1:0]   base_q, base_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic              done_q, done_d;
  logic              fault_q, fault_d;
  ptw_fault_e        code_q, code_d;
  logic [PA_W-1:0]   paddr_q, paddr_d;
  logic [2:0]        prot_q, prot_d;
  logic              cap_en;
  logic              adv_en;
  logic              res_en;

  ptw_region_e       region;
  logic [PA_W-1:0]   sp_paddr;
  logic              leaf_ok;
  ptw_fault_e        leaf_code;
  logic [2:0]        leaf_prot;
  logic [VA_W-1:0]   next_base;
  logic [PA_W-1:0]   leaf_paddr;
  logic              unused_pte_bits;

  ptw_region_decode #(
    .VA_W(VA_W), .PA_W(PA_W), .VIRT_BITS(VIRT_BITS), .MODE_W(MODE_W),
    .SP_LOW_BITS(SP_LOW_BITS), .SP_HI_POS(SP_HI_POS)
  ) u_region (
    .vaddr(va_q), .mode(mode_q), .phys_mode(phys_q),
    .region(region), .sp_paddr(sp_paddr)
  );

  ptw_index_gen #(
    .ADDR_W(VA_W), .IDX_BITS(IDX_BITS), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_index (
    .vpn(va_q[PAGE_BITS +: VPN_W]), .base(base_q), .level(lvl_q),
    .entry_addr(mem_req_addr)
  );

  ptw_leaf_check #(
    .MODE_W(MODE_W)
  ) u_leaf (
    .flags(mem_rsp_data[PTE_FLAG_W-1:0]), .access(acc_q), .mode(mode_q),
    .grant_ok(leaf_ok), .code(leaf_code), .prot(leaf_prot)
  );

  assign next_base  = VA_W'(mem_rsp_data[PTE_W-1:FRAME_LSB]) << PAGE_BITS;
  assign leaf_paddr = (PA_W'(mem_rsp_data[PTE_W-1:FRAME_LSB]) << PAGE_BITS)
                    | PA_W'(va_q[PAGE_BITS-1:0]);
  assign unused_pte_bits = ^mem_rsp_data[FRAME_LSB-1:PTE_FLAG_W];

  // next-state logic
  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    lvl_d   = lvl_q;
    cap_en  = 1'b0;
    adv_en  = 1'b0;
    res_en  = 1'b0;
    done_d  = 1'b0;
    fault_d = 1'b0;
    code_d  = code_q;
    paddr_d = paddr_q;
    prot_d  = prot_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          adv_en  = 1'b1;
          base_d  = ptbr;
          lvl_d   = '0;
          state_d = ST_DECODE;
        end
      end
      ST_DECODE: begin
        unique case (region)
          RGN_BYPASS: begin
            res_en  = 1'b1;
            done_d  = 1'b1;
            paddr_d = PA_W'(va_q);
            prot_d  = 3'b111;
            state_d = ST_IDLE;
          end
          RGN_SUPER: begin
            res_en  = 1'b1;
            done_d  = 1'b1;
            paddr_d = sp_paddr;
            prot_d  = 3'b111;
            state_d = ST_IDLE;
          end
          RGN_DENY: begin
            res_en  = 1'b1;
            fault_d = 1'b1;
            code_d  = FLT_ACV;
            paddr_d = '0;
            prot_d  = '0;
            state_d = ST_IDLE;
          end
          default: state_d = ST_ISSUE;
        endcase
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (!mem_rsp_data[PTE_V_BIT]) begin
            res_en  = 1'b1;
            fault_d = 1'b1;
            code_d  = FLT_TNV;
            paddr_d = '0;
            prot_d  = '0;
            state_d = ST_IDLE;
          end else if (lvl_q != LAST_LVL) begin
            if (!mem_rsp_data[PTE_RE_BASE]) begin
              res_en  = 1'b1;
              fault_d = 1'b1;
              code_d  = FLT_ACV;
              paddr_d = '0;
              prot_d  = '0;
              state_d = ST_IDLE;
            end else begin
              adv_en  = 1'b1;
              base_d  = next_base;
              lvl_d   = lvl_q + 1'b1;
              state_d = ST_ISSUE;
            end
          end else if (leaf_ok) begin
            res_en  = 1'b1;
            done_d  = 1'b1;
            paddr_d = leaf_paddr;
            prot_d  = leaf_prot;
            state_d = ST_IDLE;
          end else begin
            res_en  = 1'b1;
            fault_d = 1'b1;
            code_d  = leaf_code;
            paddr_d = '0;
            prot_d  = '0;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      acc_q  <= '0;
      mode_q <= '0;
      phys_q <= 1'b0;
    end else if (cap_en) begin
      va_q   <= req_vaddr;
      acc_q  <= req_access;
      mode_q <= req_mode;
      phys_q <= req_phys;
    end
  end

  // walk position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lvl_q  <= '0;
    end else if (adv_en) begin
      base_q <= base_d;
      lvl_q  <= lvl_d;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= FLT_TNV;
      paddr_q <= '0;
      prot_q  <= '0;
    end else if (res_en) begin
      code_q  <= code_d;
      paddr_q <= paddr_d;
      prot_q  <= prot_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign done          = done_q;
  assign fault         = fault_q;
  assign fault_code    = code_q;
  assign out_paddr     = paddr_q;
  assign out_prot      = prot_q;

endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk
  import ptw_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 64,
  parameter int VIRT_BITS = 43,
  parameter int MODE_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic [MODE_W-1:0] req_mode,
  input logic              req_phys,
  input logic              mem_req_valid,
  input logic              done,
  input logic              fault,
  input logic [2:0]        fault_code,
  input logic [PA_W-1:0]   out_paddr,
  input logic [2:0]        out_prot
);

  localparam int HI_W = VA_W - VIRT_BITS + 1;

  logic            accept;
  logic [HI_W-1:0] hi;
  logic            canon;
  logic            window;

  assign accept = req_valid && req_ready;
  assign hi     = req_vaddr[VA_W-1:VIRT_BITS-1];
  assign canon  = (hi == '0) || (hi == '1);
  assign window = req_vaddr[VA_W-1] && (req_vaddr[VIRT_BITS-1:VIRT_BITS-2] == 2'b10);

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_phys) |=> ##1
      (done && !fault && out_paddr == PA_W'($past(req_vaddr, 2)) && out_prot == 3'b111));

  p_noncanon_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_phys && !canon) |=> ##1 (fault && fault_code == FLT_ACV));

  p_super_user_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_phys && canon && window && req_mode != '0) |=> ##1
      (fault && fault_code == FLT_ACV));

  p_mem_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault));

  p_idle_after_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> req_ready);

endmodule

bind ptw_walker ptw_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .VIRT_BITS(VIRT_BITS), .MODE_W(MODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_mode(req_mode), .req_phys(req_phys),
  .mem_req_valid(mem_req_valid), .done(done), .fault(fault),
  .fault_code(fault_code), .out_paddr(out_paddr), .out_prot(out_prot)
);

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;

  localparam logic [63:0] PTBR = 64'h0000_0000_0001_0000;
  localparam logic [15:0] F_V = 16'h0001, F_FOR = 16'h0002, F_FOW = 16'h0004,
                          F_FOE = 16'h0008, F_KRE = 16'h0100, F_ERE = 16'h0200,
                          F_URE = 16'h0800, F_KWE = 16'h1000, F_UWE = 16'h8000;
  localparam logic [31:0] LEAF_FRAME = 32'h0000_1234;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_phys;
  logic        req_ready;
  logic [63:0] req_vaddr;
  logic [1:0]  req_access, req_mode;
  logic [63:0] ptbr;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done, fault;
  logic [2:0]  fault_code, out_prot;
  logic [63:0] out_paddr;

  always #2 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_access(req_access), .req_mode(req_mode),
    .req_phys(req_phys), .ptbr(ptbr), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
    .fault_code(fault_code), .out_paddr(out_paddr), .out_prot(out_prot)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // memory model: answers each read two cycles after the request
  logic [63:0] mem [logic [63:0]];
  logic [63:0] mlog [4];
  logic [63:0] ea [3];
  int          n_mem = 0;
  bit          pend = 0;
  int          cnt = 0;
  logic [63:0] pend_addr = '0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
        pend = 0;
      end else begin
        cnt = cnt - 1;
      end
    end
    if (mem_req_valid) begin
      pend = 1;
      cnt = 1;
      pend_addr = mem_req_addr;
      if (n_mem < 4) mlog[n_mem] = mem_req_addr;
      n_mem++;
    end
  end

  // results of the last request
  logic        g_done, g_fault;
  logic [2:0]  g_code, g_prot;
  logic [63:0] g_paddr;
  int          g_lat;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pte(input logic [31:0] frame, input logic [15:0] fl);
    return {frame, 16'h0, fl};
  endfunction

  function automatic logic [63:0] ent(input logic [63:0] base, input logic [9:0] idx);
    return base + {51'b0, idx, 3'b000};
  endfunction

  task automatic build(input logic [63:0] va, input logic [63:0] p1,
                       input logic [63:0] p2, input logic [63:0] p3);
    mem.delete();
    ea[0] = ent(PTBR, va[42:33]);
    mem[ea[0]] = p1;
    ea[1] = ent({19'b0, p1[63:32], 13'b0}, va[32:23]);
    mem[ea[1]] = p2;
    ea[2] = ent({19'b0, p2[63:32], 13'b0}, va[22:13]);
    mem[ea[2]] = p3;
  endtask

  task automatic run(input logic [63:0] va, input logic [1:0] acc,
                     input logic [1:0] mode, input bit phys, input bit poke);
    int extra;
    n_mem = 0;
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_access = acc; req_mode = mode; req_phys = phys;
    req_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      req_phys  = 1'b1;
      req_vaddr = 64'h0000_0000_0000_0005;
    end else begin
      req_valid = 1'b0;
    end
    g_lat = 0;
    do begin
      @(negedge clk);
      g_lat++;
      if (g_lat == 1) req_valid = 1'b0;
    end while (!(done || fault) && g_lat < 200);
    g_done = done; g_fault = fault; g_code = fault_code;
    g_paddr = out_paddr; g_prot = out_prot;
    chk(g_lat < 200, "R11 outcome seen", 64'(g_lat), 64'd200);
    req_phys = 1'b0;
    extra = 0;
    repeat (6) begin
      @(negedge clk);
      if (done || fault) extra++;
    end
    chk(extra == 0, "R11 single pulse", 64'(extra), 64'd0);
  endtask

  task automatic expect_fault(input string req, input logic [2:0] code, input int nm);
    chk(g_fault && !g_done, {req, " fault raised"}, {62'b0, g_done, g_fault}, 64'd1);
    chk(g_code == code, {req, " fault code"}, 64'(g_code), 64'(code));
    chk(n_mem == nm, {req, " memory reads"}, 64'(n_mem), 64'(nm));
  endtask

  task automatic t_reset;
    chk(req_ready && !done && !fault && !mem_req_valid, "R11 reset state",
        {60'b0, req_ready, done, fault, mem_req_valid}, 64'h8);
  endtask

  task automatic t_bypass;
    run(64'hDEAD_BEEF_0123_4567, 2'd1, 2'd3, 1'b1, 1'b0);
    chk(g_done && !g_fault, "R1 done", {62'b0, g_done, g_fault}, 64'd2);
    chk(g_paddr == 64'hDEAD_BEEF_0123_4567, "R1 paddr", g_paddr, 64'hDEAD_BEEF_0123_4567);
    chk(g_prot == 3'b111 && g_lat == 1, "R1 prot/latency", {g_prot, 61'(g_lat)}, {3'b111, 61'd1});
    chk(n_mem == 0, "R1 no reads", 64'(n_mem), 64'd0);
  endtask

  task automatic t_noncanon;
    run(64'h0000_0800_0000_1000, 2'd0, 2'd0, 1'b0, 1'b0);
    expect_fault("R2 bit43", 3'd1, 0);
    run(64'hFFFF_F800_0000_0000, 2'd0, 2'd0, 1'b0, 1'b0);
    expect_fault("R2 bit42", 3'd1, 0);
  endtask

  task automatic t_super;
    run(64'hFFFF_FD12_3456_789A, 2'd0, 2'd0, 1'b0, 1'b0);
    chk(g_done && g_paddr == 64'h0000_0812_3456_789A, "R3 paddr hi", g_paddr, 64'h0000_0812_3456_789A);
    chk(g_prot == 3'b111 && n_mem == 0, "R3 prot/no reads", {g_prot, 61'(n_mem)}, {3'b111, 61'd0});
    run(64'hFFFF_FC00_0000_0040, 2'd2, 2'd0, 1'b0, 1'b0);
    chk(g_done && g_paddr == 64'h40, "R3 paddr lo", g_paddr, 64'h40);
  endtask

  task automatic t_super_user;
    run(64'hFFFF_FD12_3456_789A, 2'd0, 2'd2, 1'b0, 1'b0);
    expect_fault("R4", 3'd1, 0);
  endtask

  function automatic logic [63:0] wva;
    return {21'b0, 10'h155, 10'h0AA, 10'h3C3, 13'h1ABC};
  endfunction

  function automatic logic [63:0] leaf_pa;
    return {19'b0, LEAF_FRAME, 13'h1ABC};
  endfunction

  task automatic t_walk;
    build(wva(), pte(32'h10, F_V | F_KRE), pte(32'h18, F_V | F_KRE), pte(LEAF_FRAME, F_V | F_KRE));
    run(wva(), 2'd0, 2'd0, 1'b0, 1'b0);
    chk(n_mem == 3, "R5 read count", 64'(n_mem), 64'd3);
    for (int i = 0; i < 3; i++)
      chk(mlog[i] == ea[i], "R5 entry address", mlog[i], ea[i]);
    chk(g_done && g_paddr == leaf_pa(), "R8 paddr", g_paddr, leaf_pa());
    chk(g_prot == 3'b101, "R8 kernel read grants r/x", 64'(g_prot), 64'h5);
  endtask

  task automatic t_tnv;
    build(wva(), pte(32'h10, F_KRE), pte(32'h18, F_V | F_KRE), pte(LEAF_FRAME, F_V | F_KRE));
    run(wva(), 2'd0, 2'd0, 1'b0, 1'b0);
    expect_fault("R6 level1", 3'd0, 1);
    build(wva(), pte(32'h10, F_V | F_KRE), pte(32'h18, F_KRE), pte(LEAF_FRAME, F_V | F_KRE));
    run(wva(), 2'd0, 2'd0, 1'b0, 1'b0);
    expect_fault("R6 level2", 3'd0, 2);
    build(wva(), pte(32'h10, F_V | F_KRE), pte(32'h18, F_V | F_KRE), pte(LEAF_FRAME, F_KRE | F_KWE));
    run(wva(), 2'd0, 2'd0, 1'b0, 1'b0);
    expect_fault("R6 level3", 3'd0, 3);
  endtask

  task automatic t_kre;
    build(wva(), pte(32'h10, F_V), pte(32'h18, F_V | F_KRE), pte(LEAF_FRAME, F_V | F_KRE));
    run(wva(), 2'd0, 2'd0, 1'b0, 1'b0);
    expect_fault("R7 level1", 3'd1, 1);
    build(wva(), pte(32'h10, F_V | F_KRE), pte(32'h18, F_V | F_URE), pte(LEAF_FRAME, F_V | F_KRE));
    run(wva(), 2'd0, 2'd0, 1'b0, 1'b0);
    expect_fault("R7 level2", 3'd1, 2);
  endtask

  task automatic t_perm;
    build(wva(), pte(32'h10, F_V | F_KRE), pte(32'h18, F_V | F_KRE),
          pte(LEAF_FRAME, F_V | F_KRE | F_KWE | F_URE));
    run(wva(), 2'd1, 2'd3, 1'b0, 1'b0);
    expect_fault("R9 user store", 3'd1, 3);
    mem[ea[2]] = pte(LEAF_FRAME, F_V | F_URE | F_UWE);
    run(wva(), 2'd1, 2'd3, 1'b0, 1'b0);
    chk(g_done && g_prot == 3'b111, "R8 user rwx", 64'(g_prot), 64'h7);
    mem[ea[2]] = pte(LEAF_FRAME, F_V | F_ERE);
    run(wva(), 2'd2, 2'd1, 1'b0, 1'b0);
    chk(g_done && g_prot == 3'b101, "R8 mode1 fetch", 64'(g_prot), 64'h5);
    run(wva(), 2'd2, 2'd0, 1'b0, 1'b0);
    expect_fault("R9 kernel no read", 3'd1, 3);
  endtask

  task automatic t_fault_on;
    build(wva(), pte(32'h10, F_V | F_KRE), pte(32'h18, F_V | F_KRE),
          pte(LEAF_FRAME, F_V | F_KRE | F_FOE));
    run(wva(), 2'd2, 2'd0, 1'b0, 1'b0);
    expect_fault("R10 exec", 3'd3, 3);
    run(wva(), 2'd0, 2'd0, 1'b0, 1'b0);
    chk(g_done && g_prot == 3'b001, "R10 exec removed", 64'(g_prot), 64'h1);
    mem[ea[2]] = pte(LEAF_FRAME, F_V | F_KRE | F_KWE | F_FOW);
    run(wva(), 2'd1, 2'd0, 1'b0, 1'b0);
    expect_fault("R10 write", 3'd4, 3);
    mem[ea[2]] = pte(LEAF_FRAME, F_V | F_KRE | F_FOR);
    run(wva(), 2'd0, 2'd0, 1'b0, 1'b0);
    expect_fault("R10 read", 3'd2, 3);
  endtask

  task automatic t_busy;
    build(wva(), pte(32'h10, F_V | F_KRE), pte(32'h18, F_V | F_KRE), pte(LEAF_FRAME, F_V | F_KRE));
    run(wva(), 2'd0, 2'd0, 1'b0, 1'b1);
    chk(g_done && g_paddr == leaf_pa(), "R11 busy request ignored", g_paddr, leaf_pa());
    chk(n_mem == 3, "R11 walk undisturbed", 64'(n_mem), 64'd3);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog actual=expired expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_phys = 1'b0; req_vaddr = '0;
    req_access = '0; req_mode = '0; ptbr = PTBR;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_bypass();
    t_noncanon();
    t_super();
    t_super_user();
    t_walk();
    t_tnv();
    t_kre();
    t_perm();
    t_fault_on();
    t_busy();
    summary();
  end

endmodule